// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one logic cell of a small programmable logic device. A set of product terms, made elsewhere by an AND array, is ORed into one sum. Static configuration inputs then decide how that sum reaches the outside. The sum can pass through unchanged or inverted. The cell output can be the registered copy or the sum itself. The storage flop can be clocked by the global clock pin or by a dedicated product term. It can be cleared asynchronously by the global reset pin, by a clear product term, or by both. It can be preset asynchronously by a preset product term.

On the pin side, a two-bit mode sets the role of the cell's pin. Input mode lets the pin value through to the input bus and never enables the driver. Output mode always drives the pin. Bidirectional mode gates the driver with an enable product term. Buried mode keeps the cell off its pin. A feedback output carries either the flop value, for state machines, or the polarity-adjusted sum, for expanding another cell's product terms.

Top module: `pterm_macrocell`

## Requirements
- R1: With registered output off and inversion off, the cell output equals the OR of all ten product-term inputs in the same cycle.
- R2: With the invert bit set, the sum is inverted before both the flop D input and the combinatorial path, so both output choices show the same polarity.
- R3: With registered output on and the global clock selected (clock select = 0), the cell output changes only at a rising edge of the global clock, to the value the D input had at that edge.
- R4: With clock select = 1, the flop loads only on a rising edge of the clock product term, and edges of the global clock have no effect on it.
- R5: The preset product term sets the flop to 1 at once when the preset-enable bit is 1, and has no effect when that bit is 0.
- R6: The flop is cleared to 0 at once by the reset pin when the pin-clear enable is 1, and by the clear product term when the term-clear enable is 1. Each source has no effect while its own enable is 0.
- R7: When an enabled clear and an enabled preset are active together, the flop is 0.
- R8: Pin mode 2'b01 (output) drives the cell output with the enable at 1. Pin mode 2'b10 (bidirectional) drives the cell output with the enable equal to the enable product term.
- R9: In pin mode 2'b11 (buried), the pin value and the pin enable are both 0 whatever the logic does.
- R10: In pin mode 2'b00 (input), the pin enable is 0 and the pin value is 0. The input-bus output equals the pin input in modes 2'b00 and 2'b10, and is 0 in the other modes.
- R11: The feedback output carries the flop value when the feedback-select bit is 1, and the polarity-adjusted sum when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkPin | input | 1 | Global clock pin |
| rstPin | input | 1 | Global reset pin, active high |
| ptSum | input | 10 | Product terms to be ORed |
| ptClk | input | 1 | Clock product term |
| ptPreset | input | 1 | Preset product term |
| ptClear | input | 1 | Clear product term |
| ptOe | input | 1 | Pin enable product term |
| cfgInvert | input | 1 | Invert the sum |
| cfgRegistered | input | 1 | 1 = flop output, 0 = combinatorial |
| cfgClkSel | input | 1 | 0 = global clock, 1 = clock product term |
| cfgPresetEn | input | 1 | Enable the preset term |
| cfgClrPinEn | input | 1 | Enable the reset pin as a clear |
| cfgClrPtEn | input | 1 | Enable the clear term |
| cfgFbReg | input | 1 | Feedback source: 1 = flop, 0 = sum |
| cfgPinMode | input | 2 | 00 input, 01 output, 10 bidir, 11 buried |
| pinIn | input | 1 | Value read from the pin |
| pinOut | output | 1 | Value to drive on the pin |
| pinOe | output | 1 | Pin driver enable |
| fbOut | output | 1 | Feedback to the array |
| busIn | output | 1 | Pin value passed to the input bus |

## Verification
Combinatorial results (sum, polarity, pin enable, input bus, feedback from the sum) are due in the same cycle, so the bench applies them and samples one time step later, with no clock edge between. Registered results are due at the next rising edge of whichever clock is selected. The bench therefore checks that the output still holds the old value just before that edge and holds the new value after it. Preset and clear act without a clock, so their checks follow the change of the term or enable after one time step, and the no-effect cases are sampled at the same point.

// File: rtl/pterm_mc_pkg.sv
package pterm_mc_pkg;
  localparam int PIN_MODE_W = 2;

  typedef enum logic [PIN_MODE_W-1:0] {
    PIN_INPUT  = 2'b00,
    PIN_OUTPUT = 2'b01,
    PIN_BIDIR  = 2'b10,
    PIN_BURIED = 2'b11
  } pin_mode_e;

  typedef struct packed {
    logic regClk;
    logic regClr;
    logic regPre;
    logic driveEn;
  } mc_strobes_t;
endpackage

// File: rtl/pterm_mc_ctrl.sv
module pterm_mc_ctrl
  import pterm_mc_pkg::*;
(
  input  logic        clkPin,
  input  logic        rstPin,
  input  logic        ptClk,
  input  logic        ptPreset,
  input  logic        ptClear,
  input  logic        ptOe,
  input  logic        cfgClkSel,
  input  logic        cfgPresetEn,
  input  logic        cfgClrPinEn,
  input  logic        cfgClrPtEn,
  input  pin_mode_e   cfgPinMode,
  input  logic        pinIn,
  output mc_strobes_t strobes,
  output logic        pinOe,
  output logic        busIn
);
  logic clrFromPin;
  logic clrFromTerm;

  assign clrFromPin  = rstPin & cfgClrPinEn;
  assign clrFromTerm = ptClear & cfgClrPtEn;

  always_comb begin
    strobes.regClk  = cfgClkSel ? ptClk : clkPin;
    strobes.regClr  = clrFromPin | clrFromTerm;
    strobes.regPre  = ptPreset & cfgPresetEn;
    strobes.driveEn = 1'b0;
    pinOe           = 1'b0;
    busIn           = 1'b0;
    unique case (cfgPinMode)
      PIN_INPUT: begin
        busIn = pinIn;
      end
      PIN_OUTPUT: begin
        strobes.driveEn = 1'b1;
        pinOe           = 1'b1;
      end
      PIN_BIDIR: begin
        strobes.driveEn = 1'b1;
        pinOe           = ptOe;
        busIn           = pinIn;
      end
      default: begin
        strobes.driveEn = 1'b0;
      end
    endcase
  end

  AST_INPUT_NO_DRIVE: assert property (@(posedge clkPin) disable iff (rstPin)
    (cfgPinMode == PIN_INPUT) |-> (!pinOe && !strobes.driveEn)); // R10
  AST_BURIED_QUIET: assert property (@(posedge clkPin) disable iff (rstPin)
    (cfgPinMode == PIN_BURIED) |-> (!pinOe && !busIn)); // R9
  AST_OUTPUT_ENABLED: assert property (@(posedge clkPin) disable iff (rstPin)
    (cfgPinMode == PIN_OUTPUT) |-> pinOe); // R8
endmodule

// File: rtl/pterm_mc_datapath.sv
module pterm_mc_datapath
  import pterm_mc_pkg::*;
#(
  parameter int NUM_PT = 10
) (
  input  logic              clkPin,
  input  logic              rstPin,
  input  logic [NUM_PT-1:0] ptSum,
  input  logic              cfgInvert,
  input  logic              cfgRegistered,
  input  logic              cfgClkSel,
  input  logic              cfgFbReg,
  input  mc_strobes_t       strobes,
  output logic              pinOut,
  output logic              fbOut
);
  logic orVal;
  logic dVal;
  logic qReg;
  logic cellOut;

  assign orVal   = |ptSum;
  assign dVal    = orVal ^ cfgInvert;
  assign cellOut = cfgRegistered ? qReg : dVal;
  assign pinOut  = strobes.driveEn & cellOut;
  assign fbOut   = cfgFbReg ? qReg : dVal;

  always_ff @(posedge strobes.regClk or posedge strobes.regClr or posedge strobes.regPre) begin
    if (strobes.regClr)      qReg <= 1'b0;
    else if (strobes.regPre) qReg <= 1'b1;
    else                     qReg <= dVal;
  end

  AST_CLEAR_WINS: assert property (@(posedge clkPin) disable iff (rstPin)
    strobes.regClr |-> !qReg); // R7
  AST_PRESET_SETS: assert property (@(posedge clkPin) disable iff (rstPin)
    (strobes.regPre && !strobes.regClr) |-> qReg); // R5
  AST_SYNC_CAPTURE: assert property (@(posedge clkPin) disable iff (rstPin)
    (!cfgClkSel && !strobes.regClr && !strobes.regPre)
      |=> (cfgClkSel || strobes.regClr || strobes.regPre || qReg == $past(dVal))); // R3
  AST_COMB_PATH: assert property (@(posedge clkPin) disable iff (rstPin)
    (!cfgRegistered && cfgFbReg == 1'b0) |-> (fbOut == (cfgInvert ? !(|ptSum) : (|ptSum)))); // R1
endmodule

// File: rtl/pterm_macrocell.sv
module pterm_macrocell
  import pterm_mc_pkg::*;
#(
  parameter int NUM_PT = 10
) (
  input  logic              clkPin,
  input  logic              rstPin,
  input  logic [NUM_PT-1:0] ptSum,
  input  logic              ptClk,
  input  logic              ptPreset,
  input  logic              ptClear,
  input  logic              ptOe,
  input  logic              cfgInvert,
  input  logic              cfgRegistered,
  input  logic              cfgClkSel,
  input  logic              cfgPresetEn,
  input  logic              cfgClrPinEn,
  input  logic              cfgClrPtEn,
  input  logic              cfgFbReg,
  input  logic [1:0]        cfgPinMode,
  input  logic              pinIn,
  output logic              pinOut,
  output logic              pinOe,
  output logic              fbOut,
  output logic              busIn
);
  mc_strobes_t strobes;
  pin_mode_e   pinMode;

  assign pinMode = pin_mode_e'(cfgPinMode);

  pterm_mc_ctrl ctrl_i (
    .clkPin      (clkPin),
    .rstPin      (rstPin),
    .ptClk       (ptClk),
    .ptPreset    (ptPreset),
    .ptClear     (ptClear),
    .ptOe        (ptOe),
    .cfgClkSel   (cfgClkSel),
    .cfgPresetEn (cfgPresetEn),
    .cfgClrPinEn (cfgClrPinEn),
    .cfgClrPtEn  (cfgClrPtEn),
    .cfgPinMode  (pinMode),
    .pinIn       (pinIn),
    .strobes     (strobes),
    .pinOe       (pinOe),
    .busIn       (busIn)
  );

  pterm_mc_datapath #(.NUM_PT(NUM_PT)) dp_i (
    .clkPin        (clkPin),
    .rstPin        (rstPin),
    .ptSum         (ptSum),
    .cfgInvert     (cfgInvert),
    .cfgRegistered (cfgRegistered),
    .cfgClkSel     (cfgClkSel),
    .cfgFbReg      (cfgFbReg),
    .strobes       (strobes),
    .pinOut        (pinOut),
    .fbOut         (fbOut)
  );
endmodule

// File: tb/pterm_macrocell_tb.sv
module pterm_macrocell_tb_top;
  logic       clkPin = 1'b0;
  logic       rstPin = 1'b1;
  logic [9:0] ptSum = '0;
  logic ptClk = 0, ptPreset = 0, ptClear = 0, ptOe = 1;
  logic cfgInvert = 0, cfgRegistered = 1, cfgClkSel = 0, cfgPresetEn = 0;
  logic cfgClrPinEn = 1, cfgClrPtEn = 0, cfgFbReg = 0;
  logic [1:0] cfgPinMode = 2'b01;
  logic pinIn = 0;
  logic pinOut, pinOe, fbOut, busIn;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clkPin = ~clkPin;

  pterm_macrocell dut_i (
    .clkPin(clkPin), .rstPin(rstPin), .ptSum(ptSum), .ptClk(ptClk),
    .ptPreset(ptPreset), .ptClear(ptClear), .ptOe(ptOe),
    .cfgInvert(cfgInvert), .cfgRegistered(cfgRegistered), .cfgClkSel(cfgClkSel),
    .cfgPresetEn(cfgPresetEn), .cfgClrPinEn(cfgClrPinEn), .cfgClrPtEn(cfgClrPtEn),
    .cfgFbReg(cfgFbReg), .cfgPinMode(cfgPinMode), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .fbOut(fbOut), .busIn(busIn)
  );

  typedef struct packed {
    logic [9:0] pt;
    logic       inv;
    logic [1:0] mode;
    logic       pin;
    logic       eOut;
    logic       eOe;
    logic       eBus;
    logic       eFb;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{10'h000, 1'b0, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{10'h001, 1'b0, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    '{10'h200, 1'b0, 2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    '{10'h200, 1'b1, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{10'h000, 1'b1, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    '{10'h3FF, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    '{10'h040, 1'b0, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    '{10'h000, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{10'h0F0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic atNeg();
    @(negedge clkPin);
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R6 reset state: pin clear enabled, flop output 0
    atNeg(); atNeg();
    chk("R6 reset clears flop", pinOut, 1'b0);
    chk("R11 reset feedback", fbOut, 1'b0);
    rstPin = 1'b0;

    // R1 R2 R8 R9 R10 R11 combinatorial table
    cfgRegistered = 1'b0;
    cfgFbReg = 1'b0;
    for (int i = 0; i < NV; i++) begin
      atNeg();
      ptSum = VECS[i].pt; cfgInvert = VECS[i].inv;
      cfgPinMode = VECS[i].mode; pinIn = VECS[i].pin;
      #1;
      chk("R1/R2 table pinOut", pinOut, VECS[i].eOut);
      chk("R8/R9/R10 table pinOe", pinOe, VECS[i].eOe);
      chk("R10 table busIn", busIn, VECS[i].eBus);
      chk("R11 table fbOut", fbOut, VECS[i].eFb);
    end

    // R8 bidirectional enable follows ptOe
    atNeg(); cfgPinMode = 2'b10; ptOe = 1'b0; #1;
    chk("R8 bidir oe low", pinOe, 1'b0);
    ptOe = 1'b1; #1;
    chk("R8 bidir oe high", pinOe, 1'b1);

    // R3 registered, global clock
    atNeg(); cfgPinMode = 2'b01; cfgInvert = 1'b0; ptSum = '0; cfgRegistered = 1'b1;
    atNeg(); chk("R3 starts low", pinOut, 1'b0);
    ptSum = 10'h004; #1;
    chk("R3 no change before edge", pinOut, 1'b0);
    atNeg(); chk("R3 loads at edge", pinOut, 1'b1);
    ptSum = '0; #1;
    chk("R3 holds mid cycle", pinOut, 1'b1);
    atNeg(); chk("R3 loads zero at edge", pinOut, 1'b0);

    // R2 registered polarity
    cfgInvert = 1'b1; atNeg();
    chk("R2 registered inverted", pinOut, 1'b1);
    cfgInvert = 1'b0; atNeg();
    chk("R2 registered back", pinOut, 1'b0);

    // R11 feedback from flop vs sum
    ptSum = 10'h010; cfgFbReg = 1'b1; #1;
    chk("R11 fb from flop", fbOut, 1'b0);
    cfgFbReg = 1'b0; #1;
    chk("R11 fb from sum", fbOut, 1'b1);

    // R4 product-term clock
    cfgClkSel = 1'b1; ptSum = 10'h010;
    atNeg(); atNeg();
    chk("R4 global clock ignored", pinOut, 1'b0);
    ptClk = 1'b1; #1;
    chk("R4 term clock loads", pinOut, 1'b1);
    ptClk = 1'b0; ptSum = '0; #1;
    atNeg();
    chk("R4 holds without term edge", pinOut, 1'b1);
    cfgClkSel = 1'b0; atNeg();
    chk("R3 back on global clock", pinOut, 1'b0);

    // R5 preset
    ptPreset = 1'b1; #1;
    chk("R5 preset disabled no effect", pinOut, 1'b0);
    cfgPresetEn = 1'b1; #1;
    chk("R5 preset sets", pinOut, 1'b1);
    ptPreset = 1'b0; cfgPresetEn = 1'b0; #1;

    // R6 clear term
    cfgClkSel = 1'b1; #1;
    ptClear = 1'b1; #1;
    chk("R6 term clear disabled no effect", pinOut, 1'b1);
    cfgClrPtEn = 1'b1; #1;
    chk("R6 term clear clears", pinOut, 1'b0);
    ptClear = 1'b0; cfgClrPtEn = 1'b0; #1;

    // R6 pin clear disabled
    cfgPresetEn = 1'b1; ptPreset = 1'b1; #1;
    ptPreset = 1'b0; cfgPresetEn = 1'b0; #1;
    cfgClrPinEn = 1'b0; rstPin = 1'b1; #1;
    chk("R6 pin clear disabled no effect", pinOut, 1'b1);
    cfgClrPinEn = 1'b1; #1;
    chk("R6 pin clear clears", pinOut, 1'b0);
    rstPin = 1'b0; #1;

    // R7 clear beats preset
    cfgPresetEn = 1'b1; cfgClrPtEn = 1'b1;
    ptClear = 1'b1; ptPreset = 1'b1; #1;
    chk("R7 clear wins", pinOut, 1'b0);
    ptClear = 1'b0; ptPreset = 1'b0; #1;
    cfgPresetEn = 1'b0; cfgClrPtEn = 1'b0; cfgClkSel = 1'b0;

    // R9 buried hides registered output
    cfgPinMode = 2'b11; ptSum = 10'h001; atNeg();
    chk("R9 buried pinOut", pinOut, 1'b0);
    chk("R9 buried feedback still live", fbOut, 1'b1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule